// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM Core

This block is a small synchronous static RAM whose data bus never needs an idle cycle between a read and a write. On every rising clock edge it registers one command: address, write strobe, per-byte write strobes, three chip selects, burst advance and, for an earlier write, the write data. Read data is returned either straight from the array (flow-through mode) or through an output register (pipelined mode). Write data trails its address by the same number of cycles as read data does, so the data slot of every command falls in the same position and reads and writes can be interleaved at full rate.

A burst is opened by a normal selected command and is carried on by the advance input, which produces the next address inside an aligned group of four words. The order is linear or interleaved, chosen by a static input. Two asynchronous inputs gate the data outputs: an output enable, and a sleep input that also makes the core ignore new commands. The drive enable output stands for the tri-state control of a bidirectional pin. When it is low, the data output reads zero.

Top module: `nbt_sram`

## Requirements
- R1: A command is started only when `ce1N`=0, `ce2`=1 and `ce3N`=0 are all sampled with `advance`=0. Any other combination without `advance` is a deselect: nothing is written and nothing is driven in its data slot.
- R2: Pipelined mode (`flowMode`=0): read data for an address sampled at edge n is driven during the cycle that follows edge n+1.
- R3: Flow-through mode (`flowMode`=1): read data for an address sampled at edge n is driven during the cycle that follows edge n.
- R4: Write data is sampled at edge n+2 (pipelined) or edge n+1 (flow-through) for a write address sampled at edge n. Values on `dIn` at other edges have no effect on the array.
- R5: Reads and writes may follow each other on consecutive edges in any mix, with no idle cycles, and every read returns the latest written data.
- R6: The data word is made of 9-bit lanes, lane b being bits 9b+8..9b. A lane is written only when `byteWeN[b]`=0 for that write, and the other lanes keep their old contents.
- R7: A pipelined read of an address whose write data is being sampled at the same edge that loads the output register returns that new data, merged lane by lane with the array contents.
- R8: With `interleaveMode`=0, each `advance`=1 in an open burst accesses the start address with its two low bits replaced by (start + k) mod 4 for beat k. The upper bits are unchanged.
- R9: With `interleaveMode`=1, the low two bits of beat k are (start low bits) XOR k. The upper bits are unchanged.
- R10: During `advance`, the address, `writeN` and the chip selects are ignored, and the beat keeps the read or write direction of the command that opened the burst. An `advance` with no open burst is a deselect.
- R11: `oeN`=1 forces `dOutEn` low at once, without disturbing commands already in flight.
- R12: `sleep`=1 forces `dOutEn` low at once. Commands sampled while `sleep` is high are ignored, and any open burst is closed.
- R13: While `rstN`=0 and after it is released, `dOutEn` is low, no read is pending and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of control state |
| flowMode | input | 1 | Static: 1 flow-through, 0 pipelined |
| interleaveMode | input | 1 | Static: 1 interleaved burst order, 0 linear |
| addr | input | ADDR_W | Word address |
| writeN | input | 1 | Active-low write command |
| byteWeN | input | BYTES | Active-low lane write strobes |
| ce1N | input | 1 | Active-low chip select |
| ce2 | input | 1 | Active-high chip select |
| ce3N | input | 1 | Active-low chip select |
| advance | input | 1 | Continue the open burst |
| oeN | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous power-down request |
| dIn | input | BYTES*BYTE_W | Write data |
| dOut | output | BYTES*BYTE_W | Read data, zero when not driven |
| dOutEn | output | 1 | Output drive enable |

## Verification
The assertions assume that `flowMode` and `interleaveMode` stay constant while reset is released, because the read-latency and deselect properties choose their delay from the mode. The bench changes either mode input only while `rstN` is low and clears its pipeline model at the same time. Random phases cover all four mode pairs. Inside each phase the stimulus mixes selected reads and writes, advances with junk on the ignored pins, deselects, and short pulses of `sleep` and `oeN`.

// File: rtl/nbt_sram_pkg.sv
package nbt_sram_pkg;

  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic rdNow;    // a read sits in the access stage
    logic wrNow;    // a write commits at the coming edge
    logic fwdHit;   // committing write targets the word being read
    logic flowSel;  // flow-through output path selected
  } ctrlStrobes_t;

endpackage

// File: rtl/nbt_ctrl.sv
module nbt_ctrl
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BYTES     = 2,
  parameter int BURST_LEN = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flowMode,
  input  logic               interleaveMode,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               writeN,
  input  logic [BYTES-1:0]   byteWeN,
  input  logic               ce1N,
  input  logic               ce2,
  input  logic               ce3N,
  input  logic               advance,
  input  logic               sleep,
  output ctrlStrobes_t       strb,
  output logic [ADDR_W-1:0]  rdAddr,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [BYTES-1:0]   wrBe
);
  localparam int BEAT_W = $clog2(BURST_LEN);

  typedef struct packed {
    logic              valid;
    logic              write;
    logic [ADDR_W-1:0] addr;
    logic [BYTES-1:0]  be;
  } stage_t;

  stage_t s1, s2, nxt, wrStage;
  logic startCmd, contCmd;
  logic burstActive, burstWrite;
  logic [ADDR_W-1:0] burstBase;
  logic [BEAT_W-1:0] beatCnt, nextBeat, lowBits;

  always_comb begin
    startCmd = !sleep && !advance && !ce1N && ce2 && !ce3N;
    contCmd  = !sleep && advance && burstActive;
    nextBeat = beatCnt + BEAT_W'(1);
    lowBits  = interleaveMode ? (burstBase[BEAT_W-1:0] ^ nextBeat)
                              : (burstBase[BEAT_W-1:0] + nextBeat);
    nxt.valid = startCmd || contCmd;
    nxt.write = startCmd ? !writeN : burstWrite;
    nxt.addr  = startCmd ? addr : {burstBase[ADDR_W-1:BEAT_W], lowBits};
    nxt.be    = ~byteWeN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1          <= '0;
      s2          <= '0;
      burstActive <= 1'b0;
      burstWrite  <= 1'b0;
      burstBase   <= '0;
      beatCnt     <= '0;
    end else begin
      s1          <= nxt;
      s2          <= s1;
      burstActive <= startCmd || contCmd;
      if (startCmd) begin
        burstBase  <= addr;
        beatCnt    <= '0;
        burstWrite <= !writeN;
      end else if (contCmd) begin
        beatCnt <= nextBeat;
      end
    end
  end

  // Late-write depth: one stage in flow-through, two when pipelined.
  always_comb begin
    wrStage      = flowMode ? s1 : s2;
    strb.rdNow   = s1.valid && !s1.write;
    strb.wrNow   = wrStage.valid && wrStage.write;
    strb.fwdHit  = strb.rdNow && strb.wrNow && (wrStage.addr == s1.addr);
    strb.flowSel = flowMode;
    rdAddr       = s1.addr;
    wrAddr       = wrStage.addr;
    wrBe         = wrStage.be;
  end

endmodule

// File: rtl/nbt_datapath.sv
module nbt_datapath
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobes_t              strb,
  input  logic [ADDR_W-1:0]         rdAddr,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [BYTES-1:0]          wrBe,
  input  logic [BYTES*BYTE_W-1:0]   dIn,
  input  logic                      oeN,
  input  logic                      sleep,
  output logic [BYTES*BYTE_W-1:0]   dOut,
  output logic                      dOutEn
);
  localparam int DATA_W = BYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] arrWord, merged, outReg, driveData;
  logic outValid, driveOn;

  always_ff @(posedge clk) begin
    if (strb.wrNow) begin
      for (int b = 0; b < BYTES; b++) begin
        if (wrBe[b]) mem[wrAddr][b*BYTE_W +: BYTE_W] <= dIn[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign arrWord = mem[rdAddr];

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign merged[b*BYTE_W +: BYTE_W] = (strb.fwdHit && wrBe[b])
                                        ? dIn[b*BYTE_W +: BYTE_W]
                                        : arrWord[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= strb.rdNow;
  end

  always_ff @(posedge clk) begin
    if (strb.rdNow) outReg <= merged;
  end

  always_comb begin
    driveData = strb.flowSel ? merged : outReg;
    driveOn   = strb.flowSel ? strb.rdNow : outValid;
    dOutEn    = driveOn && !oeN && !sleep;
    dOut      = dOutEn ? driveData : '0;
  end

endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BYTES     = 2,
  parameter int BYTE_W    = 9,
  parameter int BURST_LEN = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     flowMode,
  input  logic                     interleaveMode,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     writeN,
  input  logic [BYTES-1:0]         byteWeN,
  input  logic                     ce1N,
  input  logic                     ce2,
  input  logic                     ce3N,
  input  logic                     advance,
  input  logic                     oeN,
  input  logic                     sleep,
  input  logic [BYTES*BYTE_W-1:0]  dIn,
  output logic [BYTES*BYTE_W-1:0]  dOut,
  output logic                     dOutEn
);
  ctrlStrobes_t strb;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic [BYTES-1:0]  wrBe;

  nbt_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BURST_LEN(BURST_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .flowMode(flowMode), .interleaveMode(interleaveMode),
    .addr(addr), .writeN(writeN), .byteWeN(byteWeN), .ce1N(ce1N), .ce2(ce2),
    .ce3N(ce3N), .advance(advance), .sleep(sleep), .strb(strb),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .wrBe(wrBe)
  );

  nbt_datapath #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdAddr(rdAddr), .wrAddr(wrAddr),
    .wrBe(wrBe), .dIn(dIn), .oeN(oeN), .sleep(sleep), .dOut(dOut), .dOutEn(dOutEn)
  );

endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk
  import nbt_sram_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         flowMode,
  input logic         writeN,
  input logic         ce1N,
  input logic         ce2,
  input logic         ce3N,
  input logic         advance,
  input logic         oeN,
  input logic         sleep,
  input logic         dOutEn,
  input ctrlStrobes_t strb
);
  logic selected, startRead;
  assign selected  = !sleep && !advance && !ce1N && ce2 && !ce3N;
  assign startRead = selected && writeN;

  // R1
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flowMode && !advance && (ce1N || !ce2 || ce3N)) |=> !dOutEn);

  // R2
  pipe_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flowMode && startRead) |=> ##1 (dOutEn || oeN || sleep));

  // R3
  flow_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flowMode && startRead) |=> (dOutEn || oeN || sleep));

  // R5
  flow_slot_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    flowMode |-> !(strb.rdNow && strb.wrNow));

  // R11
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !dOutEn);

  // R12
  sleep_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !dOutEn);

  // R12
  sleep_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flowMode && sleep) |=> !(strb.rdNow || strb.wrNow));

endmodule

bind nbt_sram nbt_sram_chk u_chk (
  .clk(clk), .rstN(rstN), .flowMode(flowMode), .writeN(writeN), .ce1N(ce1N),
  .ce2(ce2), .ce3N(ce3N), .advance(advance), .oeN(oeN), .sleep(sleep),
  .dOutEn(dOutEn), .strb(strb)
);

// File: tb/nbt_sram_tb.sv
module nbt_sram_tb;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int BW = 9;
  localparam int DW = NB * BW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, flowMode, interleaveMode, writeN, ce1N, ce2, ce3N, advance, oeN, sleep;
  logic [AW-1:0] addr;
  logic [NB-1:0] byteWeN;
  logic [DW-1:0] dIn, dOut;
  logic dOutEn;

  nbt_sram u_dut (
    .clk(clk), .rstN(rstN), .flowMode(flowMode), .interleaveMode(interleaveMode),
    .addr(addr), .writeN(writeN), .byteWeN(byteWeN), .ce1N(ce1N), .ce2(ce2),
    .ce3N(ce3N), .advance(advance), .oeN(oeN), .sleep(sleep), .dIn(dIn),
    .dOut(dOut), .dOutEn(dOutEn)
  );

  typedef struct packed {
    logic valid, write, burst, orphan, slept;
    logic [3:0] mark;
    logic [AW-1:0] addr;
    logic [NB-1:0] be;
  } cmd_t;

  cmd_t h1, h2, prevSlot;
  logic [DW-1:0] refMem [1 << AW];
  logic bActive, bWrite;
  logic [AW-1:0] bBase;
  logic [1:0] bCnt;
  logic [3:0] markNext;
  bit flowM, ilvM;
  int checks = 0;
  int fails = 0;

  function automatic logic [AW-1:0] beatAddr(input logic [AW-1:0] base,
                                             input logic [1:0] k, input bit ilv);
    logic [1:0] lo;
    lo = ilv ? (base[1:0] ^ k) : (base[1:0] + k);
    return {base[AW-1:2], lo};
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic setDefaults();
    ce1N = 1'b1; ce2 = 1'b1; ce3N = 1'b0; advance = 1'b0; writeN = 1'b1;
    addr = '0; byteWeN = '1; oeN = 1'b0; sleep = 1'b0; dIn = '0; markNext = '0;
  endtask

  task automatic cmdStart(input bit wr, input logic [AW-1:0] a, input logic [NB-1:0] beN);
    ce1N = 1'b0; ce2 = 1'b1; ce3N = 1'b0; advance = 1'b0;
    writeN = !wr; addr = a; byteWeN = beN;
  endtask

  task automatic cmdIdle();
    ce1N = 1'b1; advance = 1'b0;
  endtask

  // One cycle: drive data slot, check outputs, model command, advance clock.
  task automatic tick();
    cmd_t slot, nc;
    logic expEn, start, cont, fwd;
    string tg;
    slot = flowM ? h1 : h2;
    dIn = DW'($urandom);
    #1;
    expEn = slot.valid && !slot.write && !oeN && !sleep;
    fwd = !flowM && prevSlot.valid && prevSlot.write && prevSlot.addr == slot.addr;
    if (slot.mark != 0)            tg = $sformatf("R%0d", slot.mark);
    else if (sleep || slot.slept)  tg = "R12";
    else if (oeN)                  tg = "R11";
    else if (!slot.valid)          tg = slot.orphan ? "R10" : "R1";
    else if (slot.write)           tg = "R5";
    else if (fwd)                  tg = "R7";
    else if (slot.burst)           tg = ilvM ? "R9" : "R8";
    else                           tg = flowM ? "R3" : "R2";
    check({tg, " drive"}, DW'(dOutEn), DW'(expEn));
    if (expEn) check({tg, " data"}, dOut, refMem[slot.addr]);
    if (slot.valid && slot.write) begin
      for (int b = 0; b < NB; b++)
        if (slot.be[b]) refMem[slot.addr][b*BW +: BW] = dIn[b*BW +: BW];
    end
    prevSlot = slot;
    start = !sleep && !advance && !ce1N && ce2 && !ce3N;
    cont  = !sleep && advance && bActive;
    nc = '0;
    nc.mark = markNext; markNext = '0;
    nc.slept = sleep;
    nc.orphan = advance && !bActive && !sleep;
    nc.be = ~byteWeN;
    if (start) begin
      nc.valid = 1'b1; nc.write = !writeN; nc.addr = addr;
      bBase = addr; bCnt = '0; bWrite = !writeN;
    end else if (cont) begin
      bCnt = bCnt + 2'd1;
      nc.valid = 1'b1; nc.write = bWrite; nc.burst = 1'b1;
      nc.addr = beatAddr(bBase, bCnt, ilvM);
    end
    bActive = start || cont;
    h2 = h1; h1 = nc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic randomTick();
    int r;
    r = int'($urandom_range(99));
    sleep = ($urandom_range(99) < 3);
    oeN   = ($urandom_range(99) < 8);
    if (r < 28) cmdStart(1'b0, AW'($urandom), NB'($urandom));
    else if (r < 56) cmdStart(1'b1, AW'($urandom), ($urandom_range(1) == 0) ? '0 : NB'($urandom));
    else if (r < 82) begin
      // R10: junk on ignored pins during advance
      advance = 1'b1; ce1N = 1'($urandom); ce2 = 1'($urandom); ce3N = 1'($urandom);
      writeN = 1'($urandom); addr = AW'($urandom); byteWeN = NB'($urandom);
    end else begin
      advance = 1'b0; ce1N = 1'b0; ce2 = 1'b1; ce3N = 1'b0;
      case ($urandom_range(2))
        0: ce1N = 1'b1;
        1: ce2 = 1'b0;
        default: ce3N = 1'b1;
      endcase
      writeN = 1'($urandom); addr = AW'($urandom);
    end
    tick();
  endtask

  task automatic runPhase(input bit fm, input bit im, input int n, input bit fill);
    setDefaults();
    rstN = 1'b0;
    flowM = fm; ilvM = im; flowMode = fm; interleaveMode = im;
    h1 = '0; h2 = '0; prevSlot = '0; bActive = 1'b0; bWrite = 1'b0; bBase = '0; bCnt = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R13 drive in reset", DW'(dOutEn), '0);
    rstN = 1'b1;
    // R13: an advance right after reset finds no burst open
    advance = 1'b1; markNext = 4'd13; tick(); advance = 1'b0;
    if (fill) begin
      for (int a = 0; a < (1 << AW); a++) begin cmdStart(1'b1, AW'(a), '0); tick(); end
    end
    // R6: full write, one-lane write, read back the merge
    cmdStart(1'b1, AW'(5), '0); tick();
    cmdStart(1'b1, AW'(5), 2'b10); tick();
    cmdStart(1'b0, AW'(5), '1); markNext = 4'd6; tick();
    // R7: read right behind a write to the same word
    cmdStart(1'b1, AW'(9), '0); tick();
    cmdStart(1'b0, AW'(9), '1); markNext = 4'd7; tick();
    // R5 and R4: alternating reads and writes, junk on dIn outside write slots
    cmdStart(1'b0, AW'(5), '1); markNext = 4'd5; tick();
    cmdStart(1'b1, AW'(12), '0); tick();
    cmdStart(1'b0, AW'(9), '1); markNext = 4'd5; tick();
    cmdStart(1'b1, AW'(13), '0); tick();
    cmdStart(1'b0, AW'(12), '1); markNext = 4'd4; tick();
    cmdStart(1'b0, AW'(13), '1); markNext = 4'd4; tick();
    // R8 / R9: directed read burst from an unaligned start
    cmdStart(1'b0, AW'(22), '1); tick();
    repeat (3) begin advance = 1'b1; ce1N = 1'b1; writeN = 1'b0; tick(); end
    cmdIdle(); repeat (3) tick();
    for (int i = 0; i < n; i++) randomTick();
    setDefaults(); repeat (3) tick();
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    runPhase(1'b0, 1'b0, 2000, 1'b1);
    runPhase(1'b0, 1'b1, 2000, 1'b0);
    runPhase(1'b1, 1'b0, 2000, 1'b0);
    runPhase(1'b1, 1'b1, 2000, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule